// File: doc/BRIEF.md
# Station Management (MDIO) Master

This block drives the two-wire management bus that a MAC uses to read and write registers inside Ethernet PHYs. It generates the management clock (MDC) from the system clock through a programmable divider. It shifts one complete frame per command onto the bidirectional data line. The data line is modelled as an output, an output enable and an input. Both the short-address frame format (start 01) and the extended-address format (start 00) are supported, and a mode bit picks between them. An extended read or write is built by software from two commands: an address frame, then the data frame.

Software programs a control word, loads a 16-bit transmit value and then writes a command word, which launches the frame. While the frame runs, a pending flag is visible in the transmit-data word for write and address frames, or in the receive-data word for read frames. A completed read leaves the received value next to a valid flag. The valid flag is set only when the PHY answered by pulling the line low in the second turnaround bit.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, MDC and the data-line enable are low, both pending flags and the valid flag are 0, and the control word (offset 0) reads 0x0000_0402: divider 4 in bits [15:8], preamble enable bit 1 set, extended-mode bit 0 clear.
- R2: While a frame runs, MDC stays high for div+1 clocks and low for div+1 clocks, where div is control bits [15:8]. MDC is low whenever no frame is pending.
- R3: In short mode (control bit 0 = 0), the command word at offset 2 has its operation in bits [1:0], the PHY address in bits [12:8] and the register address in bits [20:16]. Operation bit 0 = 0 sends line opcode 01 (write), and bit 0 = 1 sends 10 (read). The frame starts with 01.
- R4: In extended mode (control bit 0 = 1), the frame starts with 00 and the operation field is sent unchanged as the line opcode: 0 address, 1 write, 3 read. Bits [20:16] carry the device address.
- R5: With control bit 1 set, 32 ones precede the start bits, giving 64 MDC cycles per frame. With bit 1 clear, the preamble is left out and the frame is 32 MDC cycles.
- R6: Write and address frames drive turnaround 10 followed by the transmit word (offset 1, bits [15:0]), most significant bit first. Bit 31 of offset 1 reads 1 from the clock edge that accepts the command until the frame ends, and 0 otherwise.
- R7: A read frame releases the line from the first turnaround bit to the end of the frame. It captures 16 bits most significant bit first on rising MDC. Offset 3 then returns the data in [15:0] and valid = 1 in bit 30 when the second turnaround bit was low. Offset 3 bit 31 is the read-pending flag, and valid reads 0 while a read is pending.
- R8: If the second turnaround bit of a read is high (no PHY answered), valid stays 0 after the frame.
- R9: A command write while a frame is pending is dropped: the running frame completes unchanged and no further frame follows.
- R10: While the master drives the line, its value changes only on the clock edge where MDC falls. The PHY's bits are sampled on the edge where MDC rises.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 2 | Register word select |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write value |
| csr_rdata | output | 32 | Register read value (combinational on csr_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line value seen at the pin |

## Verification
The hardest case to reach is a command that lands mid-frame. The stimulus launches a write, waits twenty clocks and then issues a read to a different PHY. It then shows that the read-pending flag never rose, that the captured frame is still the write, and that MDC stays quiet afterwards. A PHY model in the bench follows MDC edges. It can either answer a read or leave the line floating high, which drives both the valid and the no-answer paths. One run also switches the preamble off, so the frame begins at the start bits.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA1_IDX    = 46;
    localparam int TA2_IDX    = 47;
    localparam int DATA_IDX   = 48;

    typedef enum logic [1:0] {
        CSR_CTRL  = 2'd0,
        CSR_WDATA = 2'd1,
        CSR_CMD   = 2'd2,
        CSR_RDATA = 2'd3
    } csr_sel_e;

    // read-type operation per clause
    function automatic logic op_is_read(input logic ext, input logic [1:0] op);
        return ext ? op[1] : op[0];
    endfunction

    // full 64-bit line image: preamble, start, opcode, phy, reg/dev, turnaround, data
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic        ext,
        input logic [1:0]  op,
        input logic [4:0]  phy,
        input logic [4:0]  dev,
        input logic [15:0] txd
    );
        logic [1:0]  st;
        logic [1:0]  line_op;
        logic [1:0]  ta;
        logic [15:0] dat;
        logic        rd;
        rd      = op_is_read(ext, op);
        st      = ext ? 2'b00 : 2'b01;
        line_op = ext ? op : {op[0], ~op[0]};
        ta      = rd ? 2'b11 : 2'b10;
        dat     = rd ? 16'hFFFF : txd;
        return {{PRE_BITS{1'b1}}, st, line_op, phy, dev, ta, dat};
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_st_t;

    div_st_t q, d;
    logic    tick;

    always_comb begin
        d    = q;
        tick = run && (q.cnt >= div);
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (tick) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc  = q.mdc;
    assign rise = tick && !q.mdc;
    assign fall = tick &&  q.mdc;

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  start_rd,
    input  logic [FRAME_BITS-1:0] start_frame,
    input  logic [IDX_W-1:0]      start_idx,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  mdio_in,
    output logic                  busy,
    output logic                  is_rd,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic [15:0]           rd_data,
    output logic                  rd_valid
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  busy;
        logic                  rd;
        logic [FRAME_BITS-1:0] frame;
        logic [IDX_W-1:0]      idx;
        logic                  ta_ok;
        logic [15:0]           shreg;
        logic [15:0]           rdata;
        logic                  valid;
    } eng_st_t;

    eng_st_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.busy  = 1'b1;
            d.rd    = start_rd;
            d.frame = start_frame;
            d.idx   = start_idx;
            d.ta_ok = 1'b0;
            if (start_rd) d.valid = 1'b0;
        end else if (q.busy) begin
            if (rise && q.rd) begin
                if (q.idx == IDX_W'(TA2_IDX)) d.ta_ok = !mdio_in;
                if (q.idx >= IDX_W'(DATA_IDX)) d.shreg = {q.shreg[14:0], mdio_in};
            end
            if (fall) begin
                if (q.idx == LAST_IDX) begin
                    d.busy = 1'b0;
                    if (q.rd) begin
                        d.rdata = q.shreg;
                        d.valid = q.ta_ok;
                    end
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign is_rd    = q.rd;
    assign mdio_o   = q.busy ? q.frame[LAST_IDX - q.idx] : 1'b1;
    assign mdio_oe  = q.busy && !(q.rd && (q.idx >= IDX_W'(TA1_IDX)));
    assign rd_data  = q.rdata;
    assign rd_valid = q.valid;

    // R9: a launch only ever reaches an idle engine
    a_r9_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);

    // R6: a frame ends on a falling MDC edge
    a_r6_ends_on_mdc_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> $past(fall));

    // R7: valid rises only as a read frame completes
    a_r7_valid_at_read_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.valid) |-> ($fell(q.busy) && q.rd));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int RST_DIV = 4,
    parameter int CSR_DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        csr_addr,
    input  logic              csr_we,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    localparam int DIV_LSB   = 8;
    localparam int PEND_BIT  = CSR_DW - 1;
    localparam int VALID_BIT = CSR_DW - 2;

    typedef struct packed {
        logic             ext;
        logic             pre_en;
        logic [DIV_W-1:0] div;
        logic [15:0]      txd;
    } cfg_st_t;

    cfg_st_t q, d;

    logic                  eng_busy, eng_rd, eng_valid;
    logic [15:0]           eng_rdata;
    logic                  mdc_rise, mdc_fall;
    logic                  launch;
    logic [1:0]            cmd_op;
    logic [FRAME_BITS-1:0] cmd_frame;
    logic [IDX_W-1:0]      cmd_idx;
    logic                  csr_unused;

    assign cmd_op     = csr_wdata[1:0];
    assign launch     = csr_we && (csr_sel_e'(csr_addr) == CSR_CMD) && !eng_busy;
    assign cmd_frame  = build_frame(q.ext, cmd_op, csr_wdata[12:8], csr_wdata[20:16], q.txd);
    assign cmd_idx    = q.pre_en ? IDX_W'(0) : IDX_W'(PRE_BITS);
    assign csr_unused = ^{csr_wdata[CSR_DW-1:21], csr_wdata[7:2]};

    always_comb begin
        d = q;
        if (csr_we) begin
            case (csr_sel_e'(csr_addr))
                CSR_CTRL: begin
                    d.ext    = csr_wdata[0];
                    d.pre_en = csr_wdata[1];
                    d.div    = csr_wdata[DIV_LSB +: DIV_W];
                end
                CSR_WDATA: d.txd = csr_wdata[15:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ext    <= 1'b0;
            q.pre_en <= 1'b1;
            q.div    <= DIV_W'(RST_DIV);
            q.txd    <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_sel_e'(csr_addr))
            CSR_CTRL: begin
                csr_rdata[0]                 = q.ext;
                csr_rdata[1]                 = q.pre_en;
                csr_rdata[DIV_LSB +: DIV_W]  = q.div;
            end
            CSR_WDATA: begin
                csr_rdata[15:0]     = q.txd;
                csr_rdata[PEND_BIT] = eng_busy && !eng_rd;
            end
            CSR_RDATA: begin
                csr_rdata[15:0]      = eng_rdata;
                csr_rdata[VALID_BIT] = eng_valid;
                csr_rdata[PEND_BIT]  = eng_busy && eng_rd;
            end
            default: ;
        endcase
    end

    mdio_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (eng_busy),
        .div  (q.div),
        .mdc  (mdc),
        .rise (mdc_rise),
        .fall (mdc_fall)
    );

    mdio_frame_eng i_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (launch),
        .start_rd   (op_is_read(q.ext, cmd_op)),
        .start_frame(cmd_frame),
        .start_idx  (cmd_idx),
        .rise       (mdc_rise),
        .fall       (mdc_fall),
        .mdio_in    (mdio_i),
        .busy       (eng_busy),
        .is_rd      (eng_rd),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .rd_data    (eng_rdata),
        .rd_valid   (eng_valid)
    );

    // R2: the clock rests low between frames
    a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdc);

    // R10: within a frame the line value moves only after an MDC fall
    a_r10_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && $past(eng_busy) && !$past(mdc_fall)) |-> $stable(mdio_o));

endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  addr;
    logic        we;
    logic [31:0] wdat;
    wire  [31:0] rdat;
    wire         mdc, mo, moe;
    wire         mi;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    int r10_viol = 0;

    logic [63:0] cap;
    int          nrise;
    logic [63:0] resp;
    int          off;
    logic        phy_line;
    logic        mo_prev, moe_prev, mdc_prev;

    always #5 clk = ~clk;

    assign mi = moe ? mo : phy_line;

    mdio_mgmt_master i_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wdat),
        .csr_rdata(rdat), .mdc(mdc), .mdio_o(mo), .mdio_oe(moe), .mdio_i(mi)
    );

    // PHY-side model: capture on rising MDC, answer after falling MDC
    always @(posedge mdc) begin
        cap   = {cap[62:0], mi};
        nrise = nrise + 1;
    end
    always @(negedge mdc) begin
        phy_line = (nrise + off < 64) ? resp[63 - (nrise + off)] : 1'b1;
    end

    // R10 monitor: driven value may change only together with an MDC fall
    always @(negedge clk) begin
        if (moe && moe_prev && (mo != mo_prev) && !(mdc_prev && !mdc)) r10_viol++;
        mo_prev  = mo;
        moe_prev = moe;
        mdc_prev = mdc;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic ext, input logic [1:0] op,
                                              input logic [4:0] phy, input logic [4:0] dev,
                                              input logic [15:0] dat);
        logic [1:0] st, lop;
        st  = ext ? 2'b00 : 2'b01;
        lop = ext ? op : (op[0] ? 2'b10 : 2'b01);
        return {32'hFFFF_FFFF, st, lop, phy, dev, 2'b10, dat};
    endfunction

    task automatic csr_wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a; wdat = v; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic csr_rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1 v = rdat;
    endtask

    task automatic wait_idle();
        logic [31:0] v1, v3;
        for (int i = 0; i < 5000; i++) begin
            csr_rd(2'd1, v1);
            csr_rd(2'd3, v3);
            if (!(v1[31] || v3[31])) break;
        end
    endtask

    task automatic prep(input logic [63:0] r, input int o);
        cap = '0; nrise = 0; resp = r; off = o; phy_line = 1'b1;
    endtask

    function automatic logic [31:0] cmd(input logic [1:0] op, input logic [4:0] phy,
                                        input logic [4:0] dev);
        return {11'd0, dev, 3'd0, phy, 6'd0, op};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 mdc", {63'd0, mdc}, 64'd0);
        chk("R1 oe", {63'd0, moe}, 64'd0);
        csr_rd(2'd0, v); chk("R1 ctrl", {32'd0, v}, 64'h402);
        csr_rd(2'd1, v); chk("R1 wr pending", {63'd0, v[31]}, 64'd0);
        csr_rd(2'd3, v); chk("R1 rd flags", {62'd0, v[31:30]}, 64'd0);
    endtask

    task automatic t_c22_write();
        logic [31:0] v;
        csr_wr(2'd0, 32'h0000_0102);
        csr_wr(2'd1, 32'h0000_A5C3);
        prep({64{1'b1}}, 0);
        csr_wr(2'd2, cmd(2'd0, 5'd5, 5'h1D));
        csr_rd(2'd1, v); chk("R6 pending set", {63'd0, v[31]}, 64'd1);
        wait_idle();
        chk("R5 bit count", 64'(nrise), 64'd64);
        chk("R3 R6 c22 write frame", cap, exp_frame(1'b0, 2'd0, 5'd5, 5'h1D, 16'hA5C3));
        csr_rd(2'd1, v); chk("R6 pending clear", {63'd0, v[31]}, 64'd0);
        chk("R10 change only on fall", 64'(r10_viol), 64'd0);
    endtask

    task automatic t_c22_read();
        logic [31:0] v;
        logic [63:0] e;
        csr_wr(2'd0, 32'h0000_0102);
        prep({{47{1'b1}}, 1'b0, 16'h3C5A}, 0);
        csr_wr(2'd2, cmd(2'd1, 5'd3, 5'd2));
        csr_rd(2'd3, v); chk("R7 read pending, valid low", {62'd0, v[31:30]}, 64'h2);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (nrise == 47) break;
        end
        chk("R7 line released", {63'd0, moe}, 64'd0);
        wait_idle();
        e = exp_frame(1'b0, 2'd1, 5'd3, 5'd2, 16'd0);
        chk("R3 c22 read header", {18'd0, cap[63:18]}, {18'd0, e[63:18]});
        csr_rd(2'd3, v); chk("R7 read result", {32'd0, v}, 64'h4000_3C5A);
    endtask

    task automatic t_read_noresp();
        logic [31:0] v;
        csr_wr(2'd0, 32'h0000_0102);
        prep({64{1'b1}}, 0);
        csr_wr(2'd2, cmd(2'd1, 5'd4, 5'd1));
        wait_idle();
        csr_rd(2'd3, v); chk("R8 no answer keeps valid low", {62'd0, v[31:30]}, 64'd0);
    endtask

    task automatic t_c45();
        logic [31:0] v;
        logic [63:0] e;
        csr_wr(2'd0, 32'h0000_0103);
        csr_wr(2'd1, 32'h0000_1234);
        prep({64{1'b1}}, 0);
        csr_wr(2'd2, cmd(2'd0, 5'd7, 5'd3));
        wait_idle();
        chk("R4 c45 address frame", cap, exp_frame(1'b1, 2'd0, 5'd7, 5'd3, 16'h1234));
        csr_wr(2'd1, 32'h0000_BEEF);
        prep({64{1'b1}}, 0);
        csr_wr(2'd2, cmd(2'd1, 5'd7, 5'd3));
        wait_idle();
        chk("R4 c45 write frame", cap, exp_frame(1'b1, 2'd1, 5'd7, 5'd3, 16'hBEEF));
        prep({{47{1'b1}}, 1'b0, 16'h0F0F}, 0);
        csr_wr(2'd2, cmd(2'd3, 5'd7, 5'd3));
        wait_idle();
        e = exp_frame(1'b1, 2'd3, 5'd7, 5'd3, 16'd0);
        chk("R4 c45 read header", {18'd0, cap[63:18]}, {18'd0, e[63:18]});
        csr_rd(2'd3, v); chk("R7 c45 read result", {32'd0, v}, 64'h4000_0F0F);
    endtask

    task automatic t_no_preamble();
        logic [63:0] e;
        csr_wr(2'd0, 32'h0000_0100);
        csr_wr(2'd1, 32'h0000_0F1E);
        prep({64{1'b1}}, 32);
        csr_wr(2'd2, cmd(2'd0, 5'd1, 5'd6));
        wait_idle();
        e = exp_frame(1'b0, 2'd0, 5'd1, 5'd6, 16'h0F1E);
        chk("R5 no preamble bit count", 64'(nrise), 64'd32);
        chk("R5 no preamble frame", {32'd0, cap[31:0]}, {32'd0, e[31:0]});
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        csr_wr(2'd0, 32'h0000_0102);
        csr_wr(2'd1, 32'h0000_0001);
        prep({64{1'b1}}, 0);
        csr_wr(2'd2, cmd(2'd0, 5'd5, 5'd1));
        repeat (20) @(negedge clk);
        csr_wr(2'd2, cmd(2'd1, 5'd9, 5'd2));
        csr_rd(2'd3, v); chk("R9 no read pending", {63'd0, v[31]}, 64'd0);
        wait_idle();
        chk("R9 first frame intact", cap, exp_frame(1'b0, 2'd0, 5'd5, 5'd1, 16'h0001));
        repeat (100) @(negedge clk);
        chk("R9 no second frame", 64'(nrise), 64'd64);
    endtask

    task automatic t_mdc_timing();
        logic smp [0:59];
        int   r1, r2, hi;
        csr_wr(2'd0, 32'h0000_0202);
        prep({64{1'b1}}, 0);
        csr_wr(2'd2, cmd(2'd0, 5'd2, 5'd2));
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            smp[i] = mdc;
        end
        r1 = -1; r2 = -1; hi = 0;
        for (int i = 1; i < 60; i++) begin
            if (!smp[i-1] && smp[i]) begin
                if (r1 < 0) r1 = i;
                else if (r2 < 0) r2 = i;
            end
        end
        for (int i = r1; i < 60; i++) begin
            if (r1 < 0 || !smp[i]) break;
            hi++;
        end
        chk("R2 mdc period", 64'(r2 - r1), 64'd6);
        chk("R2 mdc high time", 64'(hi), 64'd3);
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R2 mdc low when idle", {63'd0, mdc}, 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; we = 1'b0; addr = '0; wdat = '0;
        prep({64{1'b1}}, 0);
        mo_prev = 1'b1; moe_prev = 1'b0; mdc_prev = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_c22_write();
        t_c22_read();
        t_read_noresp();
        t_c45();
        t_no_preamble();
        t_busy_ignore();
        t_mdc_timing();
        chk("R10 change only on fall", 64'(r10_viol), 64'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule